// File: doc/BRIEF.md
# Framed Link Test Traffic Generator and Checker

This block produces and verifies counter-based test traffic for a serial radio link whose payload is cut into frames made of message groups. It works on a 32-bit word, four bytes per clock, and sits directly above an external 8b/10b encoder/decoder and serializer. The transmit half writes a slot number into every 19-byte message slot. It closes each 400-byte message group with a control character, marks the last group of each frame with a different control character, and raises a one-cycle frame pulse on the first word of each frame.

The receive half takes words that the upstream decoder has already word-aligned. It locks onto the frame boundary character and, once locked, checks every slot against counters of its own. Each mismatched bit is added to a saturating error count. Active-low status flags report lock, idle, data errors, code violations and resynchronisation. The frame length is a base group count multiplied by a rate factor of 1, 2, 4 or 8. A two-bit input selects the factor.

Top module: `link_test_top`

## Requirements
- R1: Transmit bytes are numbered from 0 within the 400-byte group, and byte lane 0 is bits 7:0, sent first. Slot s of group g, counting from reset, has global number n = 21g + s. The first three bytes of the slot carry n mod 2^24, most significant byte first. Payload byte k (0..15) carries (n + k) mod 256. The K flag is 0 on every data byte.
- R2: Byte 399 of every group, which is lane 3 of word 99, carries 0xBC with its K flag set. In the last group of a frame it carries 0xFC instead.
- R3: A frame is 100 × GROUPS_BASE × 2^rate_sel_i words long. tx_fsync_o is high for exactly the first word of each frame, including word 0 after reset.
- R4: A 0xFC boundary on the receive side moves the receiver from hunting to confirming. If every group boundary is then correct up to the next 0xFC one frame later, rx_sync_n_o goes low on the word after that character. It is high during reset.
- R5: When lock is gained, the expected counters are loaded from the first received word of the frame, so a clean loopback counts no errors.
- R6: While locked, each word adds the number of bits in which its data bytes differ from the expected bytes. The boundary byte never adds bits.
- R7: The error count (ERR_W bits, 32 by default) saturates at all ones.
- R8: A high err_clr_i clears the count and both sticky error flags at the next edge, and takes priority over an error in the same cycle.
- R9: While unlocked, the error count does not change.
- R10: One or two consecutive bad group boundaries keep the lock. The third consecutive bad boundary drops it. A boundary is bad if its byte, its K flag, or a K flag on lanes 0..2 is wrong.
- R11: rx_idle_n_o is low while the receiver is locked and the most recent group boundary was correct.
- R12: rx_data_err_n_o goes low after any counted bit error. rx_code_err_n_o goes low after any set bit of rx_code_err_i. Both stay low until cleared.
- R13: rx_resync_n_o is low from reset, goes high when lock is lost, and goes low again when lock is regained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel_i | input | 2 | Rate factor select: 2^rate_sel_i |
| tx_data_o | output | 32 | Transmit word, lane 0 in bits 7:0 |
| tx_k_o | output | 4 | Transmit control flag per lane |
| tx_fsync_o | output | 1 | High on the first word of each frame |
| rx_data_i | input | 32 | Received word, aligned |
| rx_k_i | input | 4 | Received control flag per lane |
| rx_code_err_i | input | 4 | Decoder code violation per lane |
| err_clr_i | input | 1 | Clear error count and sticky flags |
| err_count_o | output | ERR_W | Saturating bit error count |
| rx_sync_n_o | output | 1 | Low while locked |
| rx_idle_n_o | output | 1 | Low while locked with last boundary good |
| rx_data_err_n_o | output | 1 | Low once a data bit error was counted |
| rx_code_err_n_o | output | 1 | Low once a code violation was seen |
| rx_resync_n_o | output | 1 | High after lock was lost, until regained |

## Verification
The transmit word is a function of the flops only, so word n appears n edges after reset is released and is compared in that same cycle. Every receive result is registered once, so an error injected on a word shows in the count and flags one edge later. Lock appears exactly 2F edges after release, where F is the frame length in words. The bench samples a quarter period after each edge and checks each result in the cycle it is due, computed from these counts, rather than waiting an open-ended time. The only open-ended wait is reacquisition after a forced loss, and it is bounded by three frames.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int SLOT_BYTES      = 19;
    localparam int HDR_BYTES       = 3;
    localparam int SLOTS_PER_GROUP = 21;
    localparam int GROUP_BYTES     = SLOT_BYTES * SLOTS_PER_GROUP + 1;
    localparam int LANES           = 4;
    localparam int GROUP_WORDS     = GROUP_BYTES / LANES;
    localparam int OFF_W           = $clog2(SLOT_BYTES);

    localparam logic [7:0] K_GROUP = 8'hBC;
    localparam logic [7:0] K_FRAME = 8'hFC;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [23:0]      hdr;
        logic [7:0]       pay;
    } slot_pos_t;

    typedef enum logic [1:0] {ST_HUNT, ST_CONFIRM, ST_LOCKED} rx_state_t;

    function automatic logic [7:0] slot_byte(slot_pos_t s);
        logic [7:0] b;
        case (s.off)
            OFF_W'(0): b = s.hdr[23:16];
            OFF_W'(1): b = s.hdr[15:8];
            OFF_W'(2): b = s.hdr[7:0];
            default:   b = 8'(s.pay + 8'(s.off) - 8'(HDR_BYTES));
        endcase
        return b;
    endfunction

    function automatic slot_pos_t slot_step(slot_pos_t s);
        slot_pos_t n;
        n = s;
        if (s.off == OFF_W'(SLOT_BYTES - 1)) begin
            n.off = '0;
            n.hdr = s.hdr + 24'd1;
            n.pay = s.pay + 8'd1;
        end else begin
            n.off = s.off + OFF_W'(1);
        end
        return n;
    endfunction
endpackage

// File: rtl/lt_frame_pos.sv
module lt_frame_pos #(
    parameter int GROUPS_BASE = 1920,
    parameter int GROUP_WORDS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel_i,
    input  logic       restart_i,
    output logic       grp_end_o,
    output logic       frm_end_o,
    output logic       frm_start_o
);
    localparam int MAX_GROUPS = GROUPS_BASE * 8;
    localparam int GPOS_W     = $clog2(MAX_GROUPS);
    localparam int WPOS_W     = $clog2(GROUP_WORDS);

    typedef struct packed {
        logic [WPOS_W-1:0] w;
        logic [GPOS_W-1:0] g;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [GPOS_W:0]   n_groups;
    logic [GPOS_W-1:0] last_g;

    always_comb begin
        n_groups    = (GPOS_W+1)'(GROUPS_BASE) << rate_sel_i;
        last_g      = GPOS_W'(n_groups - 1'b1);
        grp_end_o   = (pos_q.w == WPOS_W'(GROUP_WORDS - 1));
        frm_end_o   = grp_end_o && (pos_q.g >= last_g);
        frm_start_o = (pos_q.w == '0) && (pos_q.g == '0);
        pos_d = pos_q;
        if (restart_i) begin
            pos_d = '0;
        end else if (grp_end_o) begin
            pos_d.w = '0;
            pos_d.g = (pos_q.g >= last_g) ? '0 : pos_q.g + 1'b1;
        end else begin
            pos_d.w = pos_q.w + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    a_r3_group_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end_o |=> (pos_q.w == '0));
endmodule

// File: rtl/lt_tx_gen.sv
module lt_tx_gen
    import lt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        grp_end_i,
    input  logic        frm_end_i,
    output logic [31:0] tx_data_o,
    output logic [3:0]  tx_k_o
);
    slot_pos_t pos_d, pos_q;

    always_comb begin
        slot_pos_t cur;
        cur       = pos_q;
        tx_data_o = '0;
        tx_k_o    = '0;
        for (int l = 0; l < LANES; l++) begin
            if (l == LANES - 1 && grp_end_i) begin
                tx_data_o[8*l +: 8] = frm_end_i ? K_FRAME : K_GROUP;
                tx_k_o[l]           = 1'b1;
            end else begin
                tx_data_o[8*l +: 8] = slot_byte(cur);
                cur                 = slot_step(cur);
            end
        end
        pos_d = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    a_r1_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.off < OFF_W'(SLOT_BYTES));
endmodule

// File: rtl/lt_rx_check.sv
module lt_rx_check
    import lt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] rx_data_i,
    input  logic [3:0]  rx_k_i,
    input  logic        grp_end_i,
    input  logic        frm_end_i,
    input  logic        frm_start_i,
    output logic        restart_o,
    output logic        locked_o,
    output logic        idle_o,
    output logic        resync_o,
    output logic [5:0]  err_bits_o
);
    localparam int MISS_LIMIT = 3;

    typedef struct packed {
        rx_state_t st;
        logic [1:0] miss;
        logic       seed;
        logic       resync;
        logic       bnd_ok;
        slot_pos_t  exp;
    } rx_t;

    rx_t r_d, r_q;
    logic bnd_good, frame_char;

    always_comb begin
        slot_pos_t cur;
        logic [7:0] diff;
        frame_char = rx_k_i[3] && (rx_data_i[31:24] == K_FRAME);
        bnd_good   = rx_k_i[3] && (rx_k_i[2:0] == '0) &&
                     (rx_data_i[31:24] == (frm_end_i ? K_FRAME : K_GROUP));
        r_d        = r_q;
        restart_o  = 1'b0;
        err_bits_o = '0;
        cur        = r_q.exp;
        diff       = '0;
        case (r_q.st)
            ST_HUNT: begin
                if (frame_char) begin
                    restart_o = 1'b1;
                    r_d.st    = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (grp_end_i) begin
                    if (!bnd_good) begin
                        r_d.st = ST_HUNT;
                    end else if (frm_end_i) begin
                        r_d.st     = ST_LOCKED;
                        r_d.seed   = 1'b1;
                        r_d.miss   = '0;
                        r_d.resync = 1'b0;
                        r_d.bnd_ok = 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (r_q.seed && frm_start_i) begin
                    cur.hdr  = {rx_data_i[7:0], rx_data_i[15:8], rx_data_i[23:16]};
                    cur.pay  = rx_data_i[31:24];
                    cur.off  = OFF_W'(LANES);
                    r_d.seed = 1'b0;
                end else begin
                    for (int l = 0; l < LANES; l++) begin
                        if (!(l == LANES - 1 && grp_end_i)) begin
                            diff       = rx_data_i[8*l +: 8] ^ slot_byte(cur);
                            err_bits_o = err_bits_o + 6'($countones(diff));
                            cur        = slot_step(cur);
                        end
                    end
                end
                if (grp_end_i) begin
                    if (bnd_good) begin
                        r_d.miss   = '0;
                        r_d.bnd_ok = 1'b1;
                    end else begin
                        r_d.bnd_ok = 1'b0;
                        if (r_q.miss == 2'(MISS_LIMIT - 1)) begin
                            r_d.st     = ST_HUNT;
                            r_d.miss   = '0;
                            r_d.resync = 1'b1;
                        end else begin
                            r_d.miss = r_q.miss + 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
        r_d.exp = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_HUNT, default: '0};
        else        r_q <= r_d;
    end

    assign locked_o = (r_q.st == ST_LOCKED);
    assign idle_o   = locked_o && r_q.bnd_ok;
    assign resync_o = r_q.resync;

    a_r4_lock_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(r_q.st) != ST_LOCKED) |-> frm_start_i);
    a_r10_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.miss < 2'(MISS_LIMIT));
    a_r13_resync_clear_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> !resync_o);
endmodule

// File: rtl/lt_err_accum.sv
module lt_err_accum #(
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [5:0]       bits_i,
    input  logic [3:0]       code_err_i,
    output logic [ERR_W-1:0] cnt_o,
    output logic             data_err_o,
    output logic             code_err_o
);
    typedef struct packed {
        logic [ERR_W-1:0] cnt;
        logic             data_err;
        logic             code_err;
    } acc_t;

    acc_t a_d, a_q;
    logic [ERR_W:0] sum;

    always_comb begin
        sum = {1'b0, a_q.cnt} + (ERR_W+1)'(bits_i);
        a_d = a_q;
        if (clr_i) begin
            a_d = '0;
        end else begin
            a_d.cnt      = sum[ERR_W] ? '1 : sum[ERR_W-1:0];
            a_d.data_err = a_q.data_err || (bits_i != '0);
            a_d.code_err = a_q.code_err || (code_err_i != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign cnt_o      = a_q.cnt;
    assign data_err_o = a_q.data_err;
    assign code_err_o = a_q.code_err;

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (a_q.cnt >= $past(a_q.cnt)));
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (a_q.cnt == '0 && !a_q.data_err && !a_q.code_err));
endmodule

// File: rtl/link_test_top.sv
module link_test_top
    import lt_pkg::*;
#(
    parameter int GROUPS_BASE = 1920,
    parameter int ERR_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel_i,
    output logic [31:0]      tx_data_o,
    output logic [3:0]       tx_k_o,
    output logic             tx_fsync_o,
    input  logic [31:0]      rx_data_i,
    input  logic [3:0]       rx_k_i,
    input  logic [3:0]       rx_code_err_i,
    input  logic             err_clr_i,
    output logic [ERR_W-1:0] err_count_o,
    output logic             rx_sync_n_o,
    output logic             rx_idle_n_o,
    output logic             rx_data_err_n_o,
    output logic             rx_code_err_n_o,
    output logic             rx_resync_n_o
);
    logic tx_grp_end, tx_frm_end;
    logic rx_grp_end, rx_frm_end, rx_frm_start, rx_restart;
    logic locked, idle, resync, data_err, code_err;
    logic [5:0] err_bits;

    lt_frame_pos #(.GROUPS_BASE(GROUPS_BASE), .GROUP_WORDS(GROUP_WORDS)) u_tx_pos (
        .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel_i), .restart_i(1'b0),
        .grp_end_o(tx_grp_end), .frm_end_o(tx_frm_end), .frm_start_o(tx_fsync_o));

    lt_tx_gen u_tx (
        .clk(clk), .rst_n(rst_n), .grp_end_i(tx_grp_end), .frm_end_i(tx_frm_end),
        .tx_data_o(tx_data_o), .tx_k_o(tx_k_o));

    lt_frame_pos #(.GROUPS_BASE(GROUPS_BASE), .GROUP_WORDS(GROUP_WORDS)) u_rx_pos (
        .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel_i), .restart_i(rx_restart),
        .grp_end_o(rx_grp_end), .frm_end_o(rx_frm_end), .frm_start_o(rx_frm_start));

    lt_rx_check u_rx (
        .clk(clk), .rst_n(rst_n), .rx_data_i(rx_data_i), .rx_k_i(rx_k_i),
        .grp_end_i(rx_grp_end), .frm_end_i(rx_frm_end), .frm_start_i(rx_frm_start),
        .restart_o(rx_restart), .locked_o(locked), .idle_o(idle),
        .resync_o(resync), .err_bits_o(err_bits));

    lt_err_accum #(.ERR_W(ERR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(err_clr_i), .bits_i(err_bits),
        .code_err_i(rx_code_err_i), .cnt_o(err_count_o),
        .data_err_o(data_err), .code_err_o(code_err));

    assign rx_sync_n_o     = !locked;
    assign rx_idle_n_o     = !idle;
    assign rx_data_err_n_o = !data_err;
    assign rx_code_err_n_o = !code_err;
    assign rx_resync_n_o   = resync;

    a_r3_fsync_after_frame_char: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_k_o[3] && tx_data_o[31:24] == K_FRAME) |=> tx_fsync_o);
    a_r9_hold_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sync_n_o && !err_clr_i) |=> $stable(err_count_o));
endmodule

// File: tb/link_test_top_bench.sv
module link_test_top_bench;
    localparam int CLK_P = 10;
    localparam int GB    = 2;
    localparam int EW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [31:0] tx_data, flip = '0;
    logic [3:0] tx_k, kflip = '0, code_err = '0;
    logic tx_fsync, err_clr = 1'b0;
    logic [EW-1:0] err_count;
    logic sync_n, idle_n, derr_n, cerr_n, resync_n;

    int checks = 0, fails = 0, kk = 0;

    always #(CLK_P/2) clk = ~clk;

    link_test_top #(.GROUPS_BASE(GB), .ERR_W(EW)) u_link_test_top (
        .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel),
        .tx_data_o(tx_data), .tx_k_o(tx_k), .tx_fsync_o(tx_fsync),
        .rx_data_i(tx_data ^ flip), .rx_k_i(tx_k ^ kflip), .rx_code_err_i(code_err),
        .err_clr_i(err_clr), .err_count_o(err_count),
        .rx_sync_n_o(sync_n), .rx_idle_n_o(idle_n), .rx_data_err_n_o(derr_n),
        .rx_code_err_n_o(cerr_n), .rx_resync_n_o(resync_n));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] model_byte(int n, int lane, int rate);
        int frames = GB << rate;
        int g = n / 100;
        int p = (n % 100) * 4 + lane;
        int slot, off;
        if (p == 399) return ((g % frames) == frames - 1) ? 9'h1FC : 9'h1BC;
        slot = g * 21 + p / 19;
        off  = p % 19;
        if (off < 3) return {1'b0, 8'((slot >> (8 * (2 - off))) & 255)};
        return {1'b0, 8'((slot + off - 3) & 255)};
    endfunction

    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
        kk++;
    endtask

    task automatic goto_word(input int m);
        while (kk % 100 != m) step();
    endtask

    task automatic do_reset(input logic [1:0] rate, input bit check_state);
        rst_n = 1'b0; rate_sel = rate; flip = '0; kflip = '0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        if (check_state) begin
            chk(sync_n == 1'b1, "R4", "sync_n in reset", sync_n, 1);
            chk(idle_n == 1'b1, "R11", "idle_n in reset", idle_n, 1);
            chk(resync_n == 1'b0, "R13", "resync_n in reset", resync_n, 0);
            chk(derr_n && cerr_n, "R12", "error flags in reset", {derr_n, cerr_n}, 3);
            chk(err_count == 0, "R7", "count in reset", err_count, 0);
        end
        rst_n = 1'b1;
        kk = 0;
    endtask

    task automatic run_rate(input logic [1:0] rate);
        int f = 100 * GB << rate;
        int tx_bad = 0, fs_bad = 0;
        logic [31:0] ed;
        logic [3:0]  ek;
        do_reset(rate, rate == 2'd1);
        for (int i = 0; i < 3 * f + 50; i++) begin
            for (int l = 0; l < 4; l++) begin
                logic [8:0] mb = model_byte(kk, l, rate);
                ed[8*l +: 8] = mb[7:0];
                ek[l]        = mb[8];
            end
            if (tx_data !== ed || tx_k !== ek) begin
                if (tx_bad == 0) chk(0, "R1", "tx word", {tx_k, tx_data}, {ek, ed});
                tx_bad++;
            end
            if (tx_fsync !== (kk % f == 0)) begin
                if (fs_bad == 0) chk(0, "R3", "fsync", tx_fsync, kk % f == 0);
                fs_bad++;
            end
            if (kk == 2 * f - 1) chk(sync_n == 1'b1, "R4", "sync before second char", sync_n, 1);
            if (kk == 2 * f) begin
                chk(sync_n == 1'b0, "R4", "sync after second char", sync_n, 0);
                chk(idle_n == 1'b0, "R11", "idle at lock", idle_n, 0);
            end
            step();
        end
        chk(tx_bad == 0, "R1", "tx words R2 boundaries over sweep", tx_bad, 0);
        chk(fs_bad == 0, "R3", "fsync positions over sweep", fs_bad, 0);
        chk(err_count == 0, "R5", "no errors after seeded lock", err_count, 0);
        chk(derr_n == 1'b1, "R5", "data error flag clean", derr_n, 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0;
        run_rate(2'd1);
        run_rate(2'd3);
        run_rate(2'd0);

        // R6: three flipped data bits
        goto_word(10);
        c0 = err_count;
        flip = 32'h0000_0007; step(); flip = '0;
        chk(err_count == c0 + 3, "R6", "count after 3 bit errors", err_count, c0 + 3);
        chk(derr_n == 1'b0, "R12", "data error flag set", derr_n, 0);

        // R6/R11: corrupted boundary byte adds nothing, drops idle
        goto_word(99);
        flip = 32'hFF00_0000; step(); flip = '0;
        chk(err_count == c0 + 3, "R6", "boundary byte not counted", err_count, c0 + 3);
        chk(idle_n == 1'b1, "R11", "idle after bad boundary", idle_n, 1);
        chk(sync_n == 1'b0, "R10", "lock held after one miss", sync_n, 0);
        goto_word(99); step();
        chk(idle_n == 1'b0, "R11", "idle after good boundary", idle_n, 0);

        // R10: two misses keep lock, three drop it
        goto_word(99); kflip = 4'h8; step(); kflip = '0;
        goto_word(99); kflip = 4'h8; step(); kflip = '0;
        chk(sync_n == 1'b0, "R10", "lock held after two misses", sync_n, 0);
        goto_word(99); step();
        goto_word(99); kflip = 4'h8; step(); kflip = '0;
        goto_word(99); kflip = 4'h8; step(); kflip = '0;
        goto_word(99); kflip = 4'h8; step(); kflip = '0;
        chk(sync_n == 1'b1, "R10", "lock lost after three misses", sync_n, 1);
        chk(resync_n == 1'b1, "R13", "resync on after loss", resync_n, 1);

        // R9: no counting while unlocked
        goto_word(20);
        c0 = err_count;
        flip = 32'hFFFF_FFFF; step(); flip = '0;
        chk(err_count == c0, "R9", "count frozen while unlocked", err_count, c0);

        // R13: regain lock
        for (int i = 0; i < 600 && sync_n; i++) step();
        chk(sync_n == 1'b0, "R13", "lock regained", sync_n, 0);
        chk(resync_n == 1'b0, "R13", "resync off after regain", resync_n, 0);

        // R12: code violation flag
        code_err = 4'b0010; step(); code_err = '0;
        chk(cerr_n == 1'b0, "R12", "code error flag set", cerr_n, 0);

        // R8: clear
        err_clr = 1'b1; step(); err_clr = 1'b0;
        chk(err_count == 0, "R8", "count cleared", err_count, 0);
        chk(derr_n && cerr_n, "R8", "flags cleared", {derr_n, cerr_n}, 3);

        // R7: saturation with full-word flips on data words
        goto_word(1);
        for (int i = 0; i < 9; i++) begin
            flip = 32'hFFFF_FFFF; step(); flip = '0;
            if (i == 6) chk(err_count == 224, "R6", "count after 7 full words", err_count, 224);
        end
        chk(err_count == 8'hFF, "R7", "count saturated", err_count, 8'hFF);

        // R8: clear beats simultaneous error
        goto_word(30);
        err_clr = 1'b1; flip = 32'h0000_00FF; step(); err_clr = 1'b0; flip = '0;
        chk(err_count == 0, "R8", "clear wins over error", err_count, 0);
        chk(derr_n == 1'b1, "R8", "flag clear wins", derr_n, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule